// File: doc/BRIEF.md
# Sparse Equation Consistency Lattice

This block decides whether a small system of sparse Boolean equations can still hold after some variables have been fixed. Every candidate solution vector of every equation is one mark bit. A set mark means that vector has been ruled out. Pairs of vector lists that share the same projection onto common variables are wired up at elaboration time as tuples. Each tuple gives two directed links. A link turns on once all vectors in its source list are marked, and it then marks every vector in its destination list. Marks only grow, so the lattice always reaches a fixpoint. At that fixpoint, one equation with every vector ruled out proves the fixed values contradictory.

The tuple sides, the equation membership and the per-variable injection masks are parameters. At run time the user gives a set of enabled variables and their values, then pulses `start`. Known constants, such as plaintext and ciphertext bits, use the same variable inputs as key guesses. Each clock cycle models one switch turn. The block raises `done` when a cycle brings no change, and it reports how many steps the run took. A guess generator upstream can use the `inconsistent` flag to reject a candidate and move to the next.

Top module: `sparse_lattice`

## Requirements
- R1: After reset, and in the cycle after a cycle with `start` high, `steps` is 0 and `done` is low. After reset `marks` is all zero. After `start`, `marks` equals exactly the injection set of the sampled guess.
- R2: A link becomes active one step after every vector in its source list is marked. It marks every vector of its destination list one step later. Links 2k and 2k+1 run from side A to side B and from side B to side A of tuple k.
- R3: A link whose source list is empty is active from the start cycle. Its destination vectors are marked in the first step.
- R4: For an enabled variable i, value 0 marks the vectors in row i of the ones-mask, and value 1 marks the vectors in row i of the zeros-mask. A disabled variable injects nothing.
- R5: The enable and value bits are sampled only in the `start` cycle. Changing them during a run does not change the result.
- R6: During a run a mark is never cleared.
- R7: `inconsistent` is high exactly when every vector of at least one equation is marked. It is low while no mark is set.
- R8: `done` rises after the first step in which neither a mark nor a link changes. While `done` is high and `start` is low, `marks`, `steps` and `done` hold.
- R9: `steps` counts the steps that changed state. It advances by one each step of a run and never exceeds the number of vectors plus the number of links.
- R10: For the default three-equation system (lists of 3, 2 and 3 vectors, seven tuples, x4 guessed on the middle equation), both x4=0 and x4=1 end with all eight vectors marked, `inconsistent` high and 7 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one propagation step per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Clears the run and samples the guess |
| guess_en | input | N_VAR | Per variable: 1 fixes the variable for this run |
| guess_val | input | N_VAR | Per variable: the fixed value |
| marks | output | N_VEC | Ruled-out flag per solution vector |
| inconsistent | output | 1 | Some equation has all of its vectors ruled out |
| done | output | 1 | Fixpoint reached; outputs held |
| steps | output | STEP_W | Number of changing steps in the run |

## Verification
The hardest case to reach from the ports is a link whose source list is empty. Such a link drives the lattice with no guess at all. The default system has none, and its effect is hidden as soon as any guess is injected. A second instance with a hand-built four-vector system has such a link and is started with all variables disabled. The bench checks that vector 0 is marked one step after `start`, before anything else can mark it. The same instance also flips the guess value in the middle of a run. This shows that only the value sampled at `start` decides the result: the final mark set differs visibly between the two values.

// File: rtl/lat_pkg.sv
package lat_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_HOLD = 2'd2
   } lat_state_e;
endpackage

// File: rtl/lat_guess_inject.sv
module lat_guess_inject #(
   parameter int N_VEC = 8,
   parameter int N_VAR = 1,
   parameter logic [N_VAR*N_VEC-1:0] ONES_MASK  = '0,
   parameter logic [N_VAR*N_VEC-1:0] ZEROS_MASK = '0
) (
   input  logic [N_VAR-1:0] en,
   input  logic [N_VAR-1:0] val,
   output logic [N_VEC-1:0] inj
);
   logic [N_VAR-1:0][N_VEC-1:0] per_var;

   for (genvar i = 0; i < N_VAR; i++) begin : g_var
      localparam logic [N_VEC-1:0] ROW1 = ONES_MASK[i*N_VEC +: N_VEC];
      localparam logic [N_VEC-1:0] ROW0 = ZEROS_MASK[i*N_VEC +: N_VEC];
      assign per_var[i] = !en[i] ? '0 : (val[i] ? ROW0 : ROW1);
   end

   always_comb begin
      inj = '0;
      for (int i = 0; i < N_VAR; i++) inj = inj | per_var[i];
   end
endmodule

// File: rtl/lat_link_gate.sv
module lat_link_gate #(
   parameter int N_VEC = 8,
   parameter int N_TUP = 7,
   parameter logic [N_TUP*N_VEC-1:0] SIDE_A = '0,
   parameter logic [N_TUP*N_VEC-1:0] SIDE_B = '0,
   localparam int N_LINK = 2 * N_TUP
) (
   input  logic [N_VEC-1:0]  marks,
   output logic [N_LINK-1:0] src_full
);
   for (genvar k = 0; k < N_TUP; k++) begin : g_tup
      for (genvar d = 0; d < 2; d++) begin : g_dir
         if (d == 0) begin : g_ab
            localparam logic [N_VEC-1:0] SRC = SIDE_A[k*N_VEC +: N_VEC];
            assign src_full[2*k] = &(marks | ~SRC);
         end else begin : g_ba
            localparam logic [N_VEC-1:0] SRC = SIDE_B[k*N_VEC +: N_VEC];
            assign src_full[2*k+1] = &(marks | ~SRC);
         end
      end
   end
endmodule

// File: rtl/lat_node_merge.sv
module lat_node_merge #(
   parameter int N_VEC = 8,
   parameter int N_TUP = 7,
   parameter logic [N_TUP*N_VEC-1:0] SIDE_A = '0,
   parameter logic [N_TUP*N_VEC-1:0] SIDE_B = '0,
   localparam int N_LINK = 2 * N_TUP
) (
   input  logic [N_VEC-1:0]  marks,
   input  logic [N_VEC-1:0]  inj,
   input  logic [N_LINK-1:0] link_act,
   output logic [N_VEC-1:0]  marks_nxt
);
   logic [N_VEC-1:0] hit;

   always_comb begin
      hit = '0;
      for (int k = 0; k < N_TUP; k++) begin
         if (link_act[2*k])   hit = hit | SIDE_B[k*N_VEC +: N_VEC];
         if (link_act[2*k+1]) hit = hit | SIDE_A[k*N_VEC +: N_VEC];
      end
      marks_nxt = marks | inj | hit;
   end
endmodule

// File: rtl/lat_eq_detect.sv
module lat_eq_detect #(
   parameter int N_VEC = 8,
   parameter int N_EQ  = 3,
   parameter logic [N_EQ*N_VEC-1:0] EQ_MEMBER = '0
) (
   input  logic [N_VEC-1:0] marks,
   output logic             any_full
);
   logic [N_EQ-1:0] full;

   for (genvar e = 0; e < N_EQ; e++) begin : g_eq
      localparam logic [N_VEC-1:0] ROW = EQ_MEMBER[e*N_VEC +: N_VEC];
      assign full[e] = &(marks | ~ROW);
   end

   assign any_full = |full;
endmodule

// File: rtl/sparse_lattice.sv
module sparse_lattice
   import lat_pkg::*;
#(
   parameter int N_VEC = 8,
   parameter int N_TUP = 7,
   parameter int N_EQ  = 3,
   parameter int N_VAR = 1,
   parameter logic [N_TUP*N_VEC-1:0] TUP_SIDE_A = 56'h04_02_01_10_08_04_03,
   parameter logic [N_TUP*N_VEC-1:0] TUP_SIDE_B = 56'h40_80_20_A0_40_10_08,
   parameter logic [N_EQ*N_VEC-1:0]  EQ_MEMBER  = 24'hE0_18_07,
   parameter logic [N_VAR*N_VEC-1:0] VAR_ONES   = 8'h08,
   parameter logic [N_VAR*N_VEC-1:0] VAR_ZEROS  = 8'h10,
   localparam int N_LINK    = 2 * N_TUP,
   localparam int MAX_STEPS = N_VEC + N_LINK,
   localparam int STEP_W    = $clog2(MAX_STEPS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [N_VAR-1:0]  guess_en,
   input  logic [N_VAR-1:0]  guess_val,
   output logic [N_VEC-1:0]  marks,
   output logic              inconsistent,
   output logic              done,
   output logic [STEP_W-1:0] steps
);
   if (N_VEC < 1 || N_TUP < 1 || N_EQ < 1 || N_VAR < 1) begin : g_bad_size
      $error("sparse_lattice: every size parameter must be at least 1");
   end
   for (genvar e = 0; e < N_EQ; e++) begin : g_chk_eq
      if (EQ_MEMBER[e*N_VEC +: N_VEC] == '0) begin : g_bad_eq
         $error("sparse_lattice: an equation has no vectors");
      end
   end
   for (genvar i = 0; i < N_VAR; i++) begin : g_chk_var
      if ((VAR_ONES[i*N_VEC +: N_VEC] & VAR_ZEROS[i*N_VEC +: N_VEC]) != '0) begin : g_bad_var
         $error("sparse_lattice: a vector sits in both masks of one variable");
      end
   end

   lat_state_e        state_q;
   logic [N_VEC-1:0]  marks_q, marks_nxt, inj_now, inj_q;
   logic [N_LINK-1:0] link_q, link_nxt, src_full, link_empty;
   logic [STEP_W-1:0] steps_q;
   logic              busy;
   logic              changed;

   lat_guess_inject #(
      .N_VEC(N_VEC), .N_VAR(N_VAR), .ONES_MASK(VAR_ONES), .ZEROS_MASK(VAR_ZEROS)
   ) u_inject (
      .en(guess_en), .val(guess_val), .inj(inj_now)
   );

   lat_link_gate #(
      .N_VEC(N_VEC), .N_TUP(N_TUP), .SIDE_A(TUP_SIDE_A), .SIDE_B(TUP_SIDE_B)
   ) u_gate (
      .marks(marks_q), .src_full(src_full)
   );

   lat_link_gate #(
      .N_VEC(N_VEC), .N_TUP(N_TUP), .SIDE_A(TUP_SIDE_A), .SIDE_B(TUP_SIDE_B)
   ) u_gate_empty (
      .marks('0), .src_full(link_empty)
   );

   lat_node_merge #(
      .N_VEC(N_VEC), .N_TUP(N_TUP), .SIDE_A(TUP_SIDE_A), .SIDE_B(TUP_SIDE_B)
   ) u_merge (
      .marks(marks_q), .inj(inj_q), .link_act(link_q), .marks_nxt(marks_nxt)
   );

   lat_eq_detect #(
      .N_VEC(N_VEC), .N_EQ(N_EQ), .EQ_MEMBER(EQ_MEMBER)
   ) u_detect (
      .marks(marks_q), .any_full(inconsistent)
   );

   assign link_nxt = link_q | src_full;
   assign changed  = (marks_nxt != marks_q) || (link_nxt != link_q);
   assign busy     = (state_q == ST_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         marks_q <= '0;
         link_q  <= '0;
         inj_q   <= '0;
         steps_q <= '0;
      end else if (start) begin
         state_q <= ST_RUN;
         inj_q   <= inj_now;
         marks_q <= inj_now;
         link_q  <= link_empty;
         steps_q <= '0;
      end else if (busy) begin
         if (changed) begin
            marks_q <= marks_nxt;
            link_q  <= link_nxt;
            steps_q <= steps_q + 1'b1;
         end else begin
            state_q <= ST_HOLD;
         end
      end
   end

   assign marks = marks_q;
   assign steps = steps_q;
   assign done  = (state_q == ST_HOLD);
endmodule

// File: rtl/lat_checker.sv
module lat_checker #(
   parameter int N_VEC     = 8,
   parameter int STEP_W    = 5,
   parameter int MAX_STEPS = 22
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [N_VEC-1:0]  marks,
   input logic              inconsistent,
   input logic              done,
   input logic [STEP_W-1:0] steps,
   input logic              busy
);
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (steps == '0 && !done && busy)); // R1

   AST_MARKS_GROW: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !start) |=> ((marks & $past(marks)) == $past(marks))); // R6

   AST_NO_MARK_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (marks == '0) |-> !inconsistent); // R7

   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(marks) && $stable(steps))); // R8

   AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !start) |=> (done || steps == $past(steps) + 1'b1)); // R9

   AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      steps <= MAX_STEPS); // R9
endmodule

bind sparse_lattice lat_checker #(
   .N_VEC(N_VEC), .STEP_W(STEP_W), .MAX_STEPS(MAX_STEPS)
) u_lat_checker (
   .clk(clk), .rst_n(rst_n), .start(start), .marks(marks),
   .inconsistent(inconsistent), .done(done), .steps(steps), .busy(busy)
);

// File: tb/sparse_lattice_bench.sv
module sparse_lattice_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic       start_a = 1'b0, en_a = 1'b0, val_a = 1'b0;
   logic [7:0] marks_a;
   logic       inc_a, done_a;
   logic [4:0] steps_a;

   logic       start_b = 1'b0, en_b = 1'b0, val_b = 1'b0;
   logic [3:0] marks_b;
   logic       inc_b, done_b;
   logic [3:0] steps_b;

   sparse_lattice u_sparse_lattice (
      .clk(clk), .rst_n(rst_n), .start(start_a), .guess_en(en_a), .guess_val(val_a),
      .marks(marks_a), .inconsistent(inc_a), .done(done_a), .steps(steps_a)
   );

   // Four vectors; equations {0,1} and {2,3}; tuple 0 = {empty ; v0}, tuple 1 = {v0 ; v1}.
   sparse_lattice #(
      .N_VEC(4), .N_TUP(2), .N_EQ(2), .N_VAR(1),
      .TUP_SIDE_A(8'h10), .TUP_SIDE_B(8'h21), .EQ_MEMBER(8'hC3),
      .VAR_ONES(4'h4), .VAR_ZEROS(4'h8)
   ) u_sparse_lattice_b (
      .clk(clk), .rst_n(rst_n), .start(start_b), .guess_en(en_b), .guess_val(val_b),
      .marks(marks_b), .inconsistent(inc_b), .done(done_b), .steps(steps_b)
   );

   typedef struct {
      logic [7:0] marks;
      int         steps;
      bit         inc;
      string      tag;
   } exp_t;

   exp_t q_a[$];
   exp_t q_b[$];
   exp_t cur_a, cur_b;
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   finished = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   // Monitors: pop the expected result when a run reaches its fixpoint.
   always @(posedge done_a) begin
      @(negedge clk);
      if (q_a.size() == 0) chk(1'b0, "R8", "A unexpected done", 32'd1, 32'd0);
      else begin
         cur_a = q_a.pop_front();
         chk(marks_a == cur_a.marks, cur_a.tag, "A final marks", marks_a, cur_a.marks);
         chk(steps_a == cur_a.steps, "R9", {cur_a.tag, " A steps"}, steps_a, cur_a.steps);
         chk(inc_a == cur_a.inc, "R7", {cur_a.tag, " A inconsistent"}, inc_a, cur_a.inc);
      end
   end

   always @(posedge done_b) begin
      @(negedge clk);
      if (q_b.size() == 0) chk(1'b0, "R8", "B unexpected done", 32'd1, 32'd0);
      else begin
         cur_b = q_b.pop_front();
         chk(marks_b == cur_b.marks[3:0], cur_b.tag, "B final marks", marks_b, cur_b.marks);
         chk(steps_b == cur_b.steps, "R9", {cur_b.tag, " B steps"}, steps_b, cur_b.steps);
         chk(inc_b == cur_b.inc, "R7", {cur_b.tag, " B inconsistent"}, inc_b, cur_b.inc);
      end
   end

   task automatic run_a(input bit en, input bit val, input logic [7:0] inj,
                        input logic [7:0] m, input int s, input bit inc, input string tag);
      exp_t x;
      x.marks = m; x.steps = s; x.inc = inc; x.tag = tag;
      q_a.push_back(x);
      @(negedge clk); en_a = en; val_a = val; start_a = 1'b1;
      @(negedge clk); start_a = 1'b0;
      chk(marks_a == inj, "R1", {tag, " marks after start (R4 injection)"}, marks_a, inj);
      chk(steps_a == 0 && !done_a, "R1", {tag, " steps/done after start"}, {steps_a, done_a}, 0);
      wait (done_a);
      repeat (4) @(negedge clk);
      chk(done_a && marks_a == m && steps_a == s, "R8", {tag, " held after done"},
          {done_a, steps_a, marks_a}, {1'b1, 5'(s), m});
   endtask

   task automatic run_b(input bit en, input bit val, input bit flip, input logic [3:0] inj,
                        input logic [3:0] m, input bit inc, input string tag);
      exp_t x;
      x.marks = {4'h0, m}; x.steps = 4; x.inc = inc; x.tag = tag;
      q_b.push_back(x);
      @(negedge clk); en_b = en; val_b = val; start_b = 1'b1;
      @(negedge clk); start_b = 1'b0;
      if (flip) val_b = ~val_b;
      chk(marks_b == inj, "R1", {tag, " B marks after start"}, marks_b, inj);
      @(negedge clk);
      // R3: the empty-source link of tuple 0 marks v0 in the first step.
      chk(marks_b == (inj | 4'h1), "R3", {tag, " B first step"}, marks_b, inj | 4'h1);
      wait (done_b);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(marks_a == 0 && !done_a && steps_a == 0 && !inc_a, "R1", "reset state",
          {marks_a, done_a, steps_a, inc_a}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 / R2: the default system rejects both values of x4.
      run_a(1'b1, 1'b0, 8'h08, 8'hFF, 7, 1'b1, "R10 x4=0");
      run_a(1'b1, 1'b1, 8'h10, 8'hFF, 7, 1'b1, "R10 x4=1");
      // R4: nothing injected when the variable is disabled; lattice stays quiet.
      run_a(1'b0, 1'b1, 8'h00, 8'h00, 0, 1'b0, "R4 disabled");
      run_a(1'b1, 1'b0, 8'h08, 8'hFF, 7, 1'b1, "R2 rerun");
      // R3: empty-source link drives instance B with no guess.
      run_b(1'b0, 1'b0, 1'b0, 4'h0, 4'h3, 1'b1, "R3 no guess");
      run_b(1'b1, 1'b1, 1'b0, 4'h8, 4'hB, 1'b1, "R4 val1");
      run_b(1'b1, 1'b0, 1'b0, 4'h4, 4'h7, 1'b1, "R4 val0");
      // R5: value flipped after start must not alter the result.
      run_b(1'b1, 1'b1, 1'b1, 4'h8, 4'hB, 1'b1, "R5 flip");
      repeat (5) @(negedge clk);
      chk(q_a.size() == 0 && q_b.size() == 0, "R8", "all runs reached done",
          q_a.size() + q_b.size(), 0);
      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         chk(1'b0, "R8", "watchdog expired", 32'd1, 32'd0);
         summary();
         $finish;
      end
   end
endmodule